// File: doc/BRIEF.md
# Timed Event Sequence Recorder and Replayer

This block captures a run of timed output events into an on-chip buffer and later replays that run as often as needed at any point on the timeline. While capture is active, each incoming event goes into the buffer with its time offset from the start of the capture, its channel number and its data word. Nothing reaches the event outputs during capture. A separate end-of-capture strobe closes the capture and supplies the total length of the run. From then on the stored run is frozen until the next capture starts.

A replay request carries a base time. The engine emits the stored events in capture order, one per cycle while the downstream sink is ready. Each event carries the base plus its stored offset. When the run is complete the engine reports the end time, which is the base plus the recorded length. The caller advances its timeline cursor to that value. Error indications from the downstream dispatcher, for late events and for out-of-order events, are forwarded upstream unchanged and are never masked.

The controller has four states. ST_IDLE waits for a command. ST_RECORD is capture. ST_PLAY emits events. ST_FINISH is a one-cycle completion step. The named transitions are:
- start-capture: ST_IDLE to ST_RECORD on a capture strobe.
- close-capture: ST_RECORD to ST_IDLE on an end strobe.
- accept-replay: ST_IDLE to ST_PLAY on an accepted request with a non-empty run.
- accept-empty: ST_IDLE to ST_FINISH on an accepted request with an empty run.
- last-handshake: ST_PLAY to ST_FINISH when the final event is taken.
- retire: ST_FINISH to ST_IDLE, always.

Top module: `evt_replay`

## Requirements
- R1: After reset `out_valid`, `play_busy`, `play_done`, `req_err`, `up_underflow` and `up_seq_err` are all 0.
- R2: `rec_start` in ST_IDLE begins a capture. Every cycle with `rec_valid` high during the capture stores one event, in arrival order. `out_valid` stays 0 for the whole capture.
- R3: Outside a capture, `rec_valid` and `rec_end` have no effect. A later replay yields exactly the previously captured events and length.
- R4: At most DEPTH events are kept per capture. Events offered once the buffer is full are discarded.
- R5: During replay event k is presented with `out_time` = base + stored offset k (TL_W-bit sum), and with its stored channel and data, for k = 0, 1, and so on in capture order.
- R6: An event is consumed in each cycle where `out_valid` and `out_ready` are both 1. While `out_ready` is 0 the presented event holds steady and none is lost. The number of replay cycles is therefore the event count plus the stall cycles.
- R7: `play_done` is high for exactly one cycle, the cycle after the last event is consumed. For an empty run it is the cycle after the request is accepted. While `play_done` is high, `play_end` equals base + recorded length.
- R8: A captured run may be replayed repeatedly at different base times with identical relative content.
- R9: A `play_req` that arrives while `play_busy` is 1, or while no closed capture exists, starts nothing and sets `req_err` from the next cycle on. An accepted request clears `req_err`.
- R10: `up_underflow` and `up_seq_err` follow `dn_underflow` and `dn_seq_err` one cycle later, regardless of state.
- R11: Starting a new capture discards the previous run. A request made before the new capture is closed is rejected as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_start | input | 1 | Begin a capture (taken in ST_IDLE) |
| rec_valid | input | 1 | Event offered for capture |
| rec_ts | input | TS_W | Offset of the offered event from capture start |
| rec_chan | input | CH_W | Channel of the offered event |
| rec_data | input | DATA_W | Data word of the offered event |
| rec_end | input | 1 | Close the capture |
| rec_dur | input | TS_W | Total run length, taken with `rec_end` |
| play_req | input | 1 | Replay request |
| play_base | input | TL_W | Timeline position for the replay |
| play_busy | output | 1 | Replay in progress (ST_PLAY or ST_FINISH) |
| play_done | output | 1 | One-cycle completion pulse |
| play_end | output | TL_W | Base plus recorded length |
| req_err | output | 1 | Last request was rejected |
| out_valid | output | 1 | Event presented downstream |
| out_ready | input | 1 | Downstream accepts the event |
| out_time | output | TL_W | Absolute event time |
| out_chan | output | CH_W | Event channel |
| out_data | output | DATA_W | Event data |
| dn_underflow | input | 1 | Downstream late-event error |
| dn_seq_err | input | 1 | Downstream ordering error |
| up_underflow | output | 1 | Forwarded late-event error |
| up_seq_err | output | 1 | Forwarded ordering error |

## Verification
An accepted request moves the engine to ST_PLAY at the next edge, so the first event is due in the cycle after the request. Each later event is due in the cycle after its predecessor's handshake. The completion pulse and end time are due in the cycle after the last handshake, and forwarded errors one cycle after they arrive. The bench drives every input on the falling edge and samples outputs just after it. It walks the replay cycle by cycle and compares every handshaken event with its own record of what was captured. It counts stall cycles so that the cycle in which `play_done` appears is checked exactly, for run lengths from empty through one past capacity.

// File: rtl/evt_replay_pkg.sv
package evt_replay_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECORD = 2'd1,
        ST_PLAY   = 2'd2,
        ST_FINISH = 2'd3
    } rp_state_e;

endpackage

// File: rtl/evt_store.sv
module evt_store #(
    parameter int DEPTH  = 256,
    parameter int TS_W   = 32,
    parameter int CH_W   = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [TS_W-1:0]   wr_ts,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TS_W-1:0]   rd_ts,
    output logic [CH_W-1:0]   rd_chan,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);

    localparam int EV_W = TS_W + CH_W + DATA_W;

    logic [EV_W-1:0] mem [DEPTH];
    logic            full;
    logic            take;

    assign full = (count == CNT_W'(DEPTH));
    assign take = wr_en && !full && !clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (take) begin
            count <= count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            mem[count[IDX_W-1:0]] <= {wr_ts, wr_chan, wr_data};
        end
    end

    always_comb begin
        {rd_ts, rd_chan, rd_data} = mem[rd_idx];
    end

    // Capacity bound: the fill count never passes the buffer depth (R4)
    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !clr |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/evt_play_ctl.sv
module evt_play_ctl
    import evt_replay_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int TS_W  = 32,
    parameter int TL_W  = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_start,
    input  logic             rec_end,
    input  logic [TS_W-1:0]  rec_dur,
    input  logic             play_req,
    input  logic [TL_W-1:0]  play_base,
    input  logic             out_ready,
    input  logic [CNT_W-1:0] count,
    input  logic [TS_W-1:0]  rd_ts,
    output logic             rec_active,
    output logic             clr,
    output logic [IDX_W-1:0] rd_idx,
    output logic             out_valid,
    output logic [TL_W-1:0]  out_time,
    output logic             busy,
    output logic             done,
    output logic [TL_W-1:0]  end_time,
    output logic             req_err
);

    rp_state_e        state, state_nx;
    logic             seq_ok;
    logic [TS_W-1:0]  dur_q;
    logic [TL_W-1:0]  base_q;
    logic [TL_W-1:0]  end_q;
    logic [IDX_W-1:0] rd_q;
    logic             err_q;
    logic             accept;
    logic             reject;
    logic             last_ev;

    assign accept  = (state == ST_IDLE) && play_req && !rec_start && seq_ok;
    assign reject  = play_req && !accept;
    assign last_ev = ((CNT_W'(rd_q) + CNT_W'(1)) == count);

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rec_start)
                    state_nx = ST_RECORD;
                else if (accept)
                    state_nx = (count == '0) ? ST_FINISH : ST_PLAY;
            end
            ST_RECORD: begin
                if (rec_end)
                    state_nx = ST_IDLE;
            end
            ST_PLAY: begin
                if (out_ready && last_ev)
                    state_nx = ST_FINISH;
            end
            ST_FINISH: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_ok <= 1'b0;
            dur_q  <= '0;
            base_q <= '0;
            end_q  <= '0;
            rd_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            if ((state == ST_IDLE) && rec_start)
                seq_ok <= 1'b0;
            if ((state == ST_RECORD) && rec_end) begin
                seq_ok <= 1'b1;
                dur_q  <= rec_dur;
            end
            if (accept) begin
                base_q <= play_base;
                end_q  <= play_base + TL_W'(dur_q);
                rd_q   <= '0;
                err_q  <= 1'b0;
            end else if (reject) begin
                err_q  <= 1'b1;
            end
            if ((state == ST_PLAY) && out_ready && !last_ev)
                rd_q <= rd_q + IDX_W'(1);
        end
    end

    // outputs
    always_comb begin
        rec_active = 1'b0;
        clr        = 1'b0;
        out_valid  = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clr = rec_start;
            end
            ST_RECORD: begin
                rec_active = 1'b1;
            end
            ST_PLAY: begin
                out_valid = 1'b1;
                busy      = 1'b1;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
        rd_idx   = rd_q;
        out_time = base_q + TL_W'(rd_ts);
        end_time = end_q;
        req_err  = err_q;
    end

    // Completion is a single-cycle pulse (R7)
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A request that meets a busy engine or no closed capture flags an error (R9)
    p_reject_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        play_req && (busy || !seq_ok) |=> req_err);

    // During capture nothing is issued downstream (R2)
    p_quiet_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_active |=> !out_valid || !$past(rec_active) || (state == ST_IDLE));

endmodule

// File: rtl/evt_err_relay.sv
module evt_err_relay #(
    parameter int N_ERR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] err_in,
    output logic [N_ERR-1:0] err_out
);

    for (genvar g = 0; g < N_ERR; g++) begin : g_relay
        always_ff @(posedge clk) begin
            if (!rst_n)
                err_out[g] <= 1'b0;
            else
                err_out[g] <= err_in[g];
        end

        // Each downstream error is forwarded one cycle later (R10)
        p_fwd_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
            err_in[g] |=> err_out[g]);
        p_fwd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !err_in[g] |=> !err_out[g]);
    end

endmodule

// File: rtl/evt_replay.sv
module evt_replay #(
    parameter int DEPTH  = 256,
    parameter int TS_W   = 32,
    parameter int CH_W   = 8,
    parameter int DATA_W = 32,
    parameter int TL_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_start,
    input  logic              rec_valid,
    input  logic [TS_W-1:0]   rec_ts,
    input  logic [CH_W-1:0]   rec_chan,
    input  logic [DATA_W-1:0] rec_data,
    input  logic              rec_end,
    input  logic [TS_W-1:0]   rec_dur,
    input  logic              play_req,
    input  logic [TL_W-1:0]   play_base,
    output logic              play_busy,
    output logic              play_done,
    output logic [TL_W-1:0]   play_end,
    output logic              req_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TL_W-1:0]   out_time,
    output logic [CH_W-1:0]   out_chan,
    output logic [DATA_W-1:0] out_data,
    input  logic              dn_underflow,
    input  logic              dn_seq_err,
    output logic              up_underflow,
    output logic              up_seq_err
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             rec_active;
    logic             clr;
    logic             wr_en;
    logic [IDX_W-1:0] rd_idx;
    logic [TS_W-1:0]  rd_ts;
    logic [CNT_W-1:0] count;
    logic [1:0]       err_up;

    assign wr_en = rec_active && rec_valid;

    evt_store #(
        .DEPTH (DEPTH),
        .TS_W  (TS_W),
        .CH_W  (CH_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .wr_en  (wr_en),
        .wr_ts  (rec_ts),
        .wr_chan(rec_chan),
        .wr_data(rec_data),
        .rd_idx (rd_idx),
        .rd_ts  (rd_ts),
        .rd_chan(out_chan),
        .rd_data(out_data),
        .count  (count)
    );

    evt_play_ctl #(
        .DEPTH(DEPTH),
        .TS_W (TS_W),
        .TL_W (TL_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_start (rec_start),
        .rec_end   (rec_end),
        .rec_dur   (rec_dur),
        .play_req  (play_req),
        .play_base (play_base),
        .out_ready (out_ready),
        .count     (count),
        .rd_ts     (rd_ts),
        .rec_active(rec_active),
        .clr       (clr),
        .rd_idx    (rd_idx),
        .out_valid (out_valid),
        .out_time  (out_time),
        .busy      (play_busy),
        .done      (play_done),
        .end_time  (play_end),
        .req_err   (req_err)
    );

    evt_err_relay #(
        .N_ERR(2)
    ) u_relay (
        .clk    (clk),
        .rst_n  (rst_n),
        .err_in ({dn_seq_err, dn_underflow}),
        .err_out(err_up)
    );

    assign up_underflow = err_up[0];
    assign up_seq_err   = err_up[1];

    // A stalled event stays put until it is taken (R6)
    p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_time)
                                    && $stable(out_chan) && $stable(out_data));

    // Outside capture the stored run is frozen (R3)
    p_frozen_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_active && !rec_start |=> $stable(count));

endmodule

// File: tb/evt_replay_test.sv
module evt_replay_test;

    localparam int DEPTH  = 8;
    localparam int TS_W   = 32;
    localparam int CH_W   = 8;
    localparam int DATA_W = 32;
    localparam int TL_W   = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rec_start, rec_valid, rec_end;
    logic [TS_W-1:0]   rec_ts, rec_dur;
    logic [CH_W-1:0]   rec_chan;
    logic [DATA_W-1:0] rec_data;
    logic              play_req;
    logic [TL_W-1:0]   play_base;
    logic              play_busy, play_done, req_err;
    logic [TL_W-1:0]   play_end;
    logic              out_valid, out_ready;
    logic [TL_W-1:0]   out_time;
    logic [CH_W-1:0]   out_chan;
    logic [DATA_W-1:0] out_data;
    logic              dn_underflow, dn_seq_err, up_underflow, up_seq_err;

    always #5 clk = ~clk;

    evt_replay #(
        .DEPTH(DEPTH), .TS_W(TS_W), .CH_W(CH_W), .DATA_W(DATA_W), .TL_W(TL_W)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .rec_start(rec_start), .rec_valid(rec_valid), .rec_ts(rec_ts),
        .rec_chan(rec_chan), .rec_data(rec_data), .rec_end(rec_end),
        .rec_dur(rec_dur), .play_req(play_req), .play_base(play_base),
        .play_busy(play_busy), .play_done(play_done), .play_end(play_end),
        .req_err(req_err), .out_valid(out_valid), .out_ready(out_ready),
        .out_time(out_time), .out_chan(out_chan), .out_data(out_data),
        .dn_underflow(dn_underflow), .dn_seq_err(dn_seq_err),
        .up_underflow(up_underflow), .up_seq_err(up_seq_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [TS_W-1:0]   e_ts [DEPTH];
    logic [CH_W-1:0]   e_ch [DEPTH];
    logic [DATA_W-1:0] e_dt [DEPTH];
    int                e_n;
    logic [TS_W-1:0]   e_dur;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [TS_W-1:0] ev_ts(int n, int i);
        return TS_W'(i * 7 + n * 3 + 1);
    endfunction

    // R2 R4: capture n events; bench keeps the first DEPTH of them
    task automatic do_record(int n, int salt);
        @(negedge clk);
        rec_start = 1'b1;
        @(negedge clk);
        rec_start = 1'b0;
        e_n = 0;
        for (int i = 0; i < n; i++) begin
            rec_valid = 1'b1;
            rec_ts    = ev_ts(n, i);
            rec_chan  = CH_W'(n * 16 + i + salt);
            rec_data  = 32'hA500_0000 ^ DATA_W'(n << 8) ^ DATA_W'(i) ^ DATA_W'(salt << 20);
            if (e_n < DEPTH) begin
                e_ts[e_n] = rec_ts; e_ch[e_n] = rec_chan; e_dt[e_n] = rec_data;
                e_n++;
            end
            #1;
            chk(out_valid == 1'b0, "R2 no output during capture", 64'(out_valid), 64'h0);
            @(negedge clk);
        end
        rec_valid = 1'b0;
        rec_end   = 1'b1;
        rec_dur   = ev_ts(n, n) + TS_W'(5);
        e_dur     = rec_dur;
        @(negedge clk);
        rec_end = 1'b0;
    endtask

    // R5 R6 R7 R8: replay and compare every handshake
    task automatic do_play(logic [TL_W-1:0] base, logic [31:0] pat, bit poke_busy);
        int k = 0;
        int stalls = 0;
        bit seen = 1'b0;
        @(negedge clk);
        play_req  = 1'b1;
        play_base = base;
        @(negedge clk);
        play_req = 1'b0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            out_ready = pat[cyc % 32];
            play_req  = poke_busy && (cyc == 1);
            #1;
            if (cyc == 0)
                chk(req_err == 1'b0, "R9 accepted request clears flag", 64'(req_err), 64'h0);
            if (poke_busy && cyc == 2)
                chk(req_err == 1'b1, "R9 request while busy flagged", 64'(req_err), 64'h1);
            if (play_done) begin
                chk(k == e_n, "R6 all events delivered", 64'(k), 64'(e_n));
                chk(cyc == e_n + stalls, "R7 done cycle", 64'(cyc), 64'(e_n + stalls));
                chk(play_end == base + TL_W'(e_dur), "R7 end time",
                    play_end, base + TL_W'(e_dur));
                chk(out_valid == 1'b0, "R7 no event with done", 64'(out_valid), 64'h0);
                seen = 1'b1;
                break;
            end
            if (out_valid && !out_ready) stalls++;
            if (out_valid && out_ready) begin
                if (k < e_n) begin
                    chk(out_time == base + TL_W'(e_ts[k]), "R5 event time",
                        out_time, base + TL_W'(e_ts[k]));
                    chk(out_chan == e_ch[k], "R5 event channel", 64'(out_chan), 64'(e_ch[k]));
                    chk(out_data == e_dt[k], "R5 event data", 64'(out_data), 64'(e_dt[k]));
                end else begin
                    chk(1'b0, "R4 extra event emitted", 64'(k), 64'(e_n));
                end
                k++;
            end
            @(negedge clk);
        end
        play_req = 1'b0;
        chk(seen, "R7 done seen", 64'(seen), 64'h1);
        out_ready = 1'b0;
        @(negedge clk);
        #1;
        chk(play_busy == 1'b0, "R7 idle after done", 64'(play_busy), 64'h0);
        chk(play_done == 1'b0, "R7 done single cycle", 64'(play_done), 64'h0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0;
        rec_start = 0; rec_valid = 0; rec_end = 0;
        rec_ts = 0; rec_chan = 0; rec_data = 0; rec_dur = 0;
        play_req = 0; play_base = 0; out_ready = 0;
        dn_underflow = 0; dn_seq_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 0, "R1 out_valid", 64'(out_valid), 0);
        chk(play_busy == 0, "R1 busy", 64'(play_busy), 0);
        chk(play_done == 0, "R1 done", 64'(play_done), 0);
        chk(req_err == 0, "R1 req_err", 64'(req_err), 0);
        chk(up_underflow == 0 && up_seq_err == 0, "R1 relays",
            64'({up_seq_err, up_underflow}), 0);

        // R9: request with nothing captured
        @(negedge clk);
        play_req = 1'b1;
        @(negedge clk);
        play_req = 1'b0;
        #1;
        chk(req_err == 1'b1, "R9 no run flagged", 64'(req_err), 1);
        chk(play_busy == 1'b0, "R9 no run not started", 64'(play_busy), 0);

        // Sweep run lengths empty through one past capacity
        for (int n = 0; n <= DEPTH + 1; n++) begin
            do_record(n, 0);
            do_play(64'h0000_0000_FFFF_FF00 + 64'(n * 1000), 32'hFFFF_FFFF, 1'b0);
            do_play(64'h1234_0000_0000_0000 + 64'(n), 32'h5A5A_C3C6, n == 4);
        end

        // R3: capture-side strobes outside a capture are ignored
        do_record(5, 9);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rec_valid = 1'b1; rec_ts = 32'hDEAD; rec_chan = 8'hEE; rec_data = 32'hBAD;
            rec_end = (i == 2); rec_dur = 32'h7777;
        end
        @(negedge clk);
        rec_valid = 0; rec_end = 0;
        #1;
        chk(out_valid == 0, "R3 idle strobes issue nothing", 64'(out_valid), 0);
        // R3 R8: same content again at a new base
        do_play(64'd77, 32'hFFFF_FFFF, 1'b0);
        do_play(64'hFFFF_FFFF_FFFF_0000, 32'h0F0F_0F0E, 1'b0);

        // R11: a new capture invalidates the old run until closed
        @(negedge clk);
        rec_start = 1'b1;
        @(negedge clk);
        rec_start = 1'b0;
        play_req  = 1'b1;
        @(negedge clk);
        play_req = 1'b0;
        #1;
        chk(req_err == 1'b1, "R11 request during capture rejected", 64'(req_err), 1);
        chk(out_valid == 1'b0, "R11 no output during capture", 64'(out_valid), 0);
        rec_end = 1'b1; rec_dur = 32'd40;
        @(negedge clk);
        rec_end = 1'b0;
        e_n = 0; e_dur = 32'd40;
        do_play(64'd500, 32'hFFFF_FFFF, 1'b0);

        // R10: error forwarding, all four combinations
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            dn_underflow = c[0]; dn_seq_err = c[1];
            @(negedge clk);
            #1;
            chk(up_underflow == c[0], "R10 underflow forwarded", 64'(up_underflow), 64'(c[0]));
            chk(up_seq_err == c[1], "R10 order error forwarded", 64'(up_seq_err), 64'(c[1]));
        end
        @(negedge clk);
        dn_underflow = 0; dn_seq_err = 0;
        @(negedge clk);
        finished = 1'b1;
        summary();
    end

endmodule